// File: doc/BRIEF.md
# Two-Stage APB Watchdog Timer

This peripheral is a 32-bit down-counting watchdog with an APB slave register port. The counter steps down by one on every clock where the counter enable input is high. When the count first runs out, the raw interrupt flag is set and the count starts again from the reload value. If software has not cleared the flag by the time the count runs out again, a sticky reset status is set and the counter freezes at zero. Two control bits gate the interrupt and the reset request at the outputs.

A magic-key lock guards every register except the lock register itself. An integration-test mode lets software drive both outputs directly. A bank of read-only identification bytes sits at the top of the 4 KB window. The `VARIANT` parameter selects an alternate flavour with three differences: the control register cannot be changed once its interrupt-enable bit is set, the integration registers and the clear offset do not exist, and the identification bytes differ.

Top module: `wdog_apb_twostage`

## Requirements
- R1: After reset the reload value and the counter are 0xFFFFFFFF and the counter is running. Control, raw interrupt, reset status, lock, integration control and integration output are all 0, and both outputs are low.
- R2: On each clock with `cntEn` high while running, the counter (read at offset 0x004) drops by exactly one. Writes to 0x004, 0x010 and 0x014 change nothing.
- R3: A write to offset 0x000 stores the reload value, loads the counter with that value at once, and restarts counting, including after the counter has frozen.
- R4: An enabled clock that finds the counter at 1 (or 0) while the raw interrupt is clear sets the raw interrupt (bit 0 of offset 0x010) and reloads the counter from the reload value.
- R5: An enabled clock that finds the counter at 1 (or 0) while the raw interrupt is already set sets the reset status. The counter then holds 0 until a write to offset 0x000.
- R6: In the standard flavour, a write of any data to offset 0x00C clears the raw interrupt and reloads the counter from the reload value.
- R7: Control at 0x008 keeps only bits [1:0] and reads the rest as 0. Offset 0x014 reads raw AND bit 0. `wdogInt` is raw AND bit 0. `wdogRstReq` is reset status AND bit 1.
- R8: Writing 0x1ACCE551 to offset 0xC00 unlocks the block and any other value locks it. 0xC00 reads 1 when locked and 0 when unlocked. While locked, writes to every other offset are ignored.
- R9: In the standard flavour, when bit 0 of offset 0xF00 is set, bit 0 of offset 0xF04 drives `wdogRstReq` and bit 1 drives `wdogInt`. Offset 0xF04 reads 0.
- R10: Offsets 0xFD0..0xFFC read one byte each in this order: 0x04,0,0,0, 0x24,0xB8,0x1B,0x00, 0x0D,0xF0,0x05,0xB1.
- R11: With `VARIANT`=1, control writes are ignored once control bit 0 is 1. Writes to 0x00C, 0xF00 and 0xF04 have no effect and those offsets read 0. The first eight identification bytes are instead 0,0,0,0, 0x05,0x18,0x18,0x01.
- R12: Reads of unmapped or unaligned offsets return 0. `pReady` is always 1 and `pSlvErr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pClk | input | 1 | Bus and counter clock |
| pResetN | input | 1 | Active-low synchronous reset |
| pSel | input | 1 | Slave select |
| pEnable | input | 1 | Access phase |
| pWrite | input | 1 | 1 for write |
| pAddr | input | ADDR_W | Byte offset |
| pWdata | input | 32 | Write data |
| pRdata | output | 32 | Read data |
| pReady | output | 1 | Always ready |
| pSlvErr | output | 1 | Always 0 |
| cntEn | input | 1 | Counter clock enable |
| wdogInt | output | 1 | Interrupt output |
| wdogRstReq | output | 1 | Reset request output |

## Verification
A write takes effect on the rising edge that ends its access phase, so its register contents and the two outputs are due one cycle later. The bench drives on falling edges and samples only after the transfer has finished. Read data is combinational during the access phase and is sampled just after the falling edge, before the closing rising edge. Each counter step lands on a rising edge with `cntEn` high. The bench raises `cntEn` on a falling edge, counts exactly n rising edges, and lowers it again, so the expected count is plain arithmetic on n.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int WORD_W   = 32;
  localparam int OFF_LOAD = 'h000;
  localparam int OFF_CNT  = 'h004;
  localparam int OFF_CTRL = 'h008;
  localparam int OFF_CLR  = 'h00C;
  localparam int OFF_RAW  = 'h010;
  localparam int OFF_MSK  = 'h014;
  localparam int OFF_LOCK = 'hC00;
  localparam int OFF_ITC  = 'hF00;
  localparam int OFF_ITO  = 'hF04;
  localparam int ID_BASE  = 'hFD0;
  localparam int ID_NUM   = 12;

  typedef struct packed {
    logic              loadWr;
    logic              intClr;
    logic [WORD_W-1:0] data;
  } wdogStrb_t;

  function automatic logic [7:0] idByte(input int idx, input bit alt);
    logic [7:0] b;
    case (idx)
      0:  b = alt ? 8'h00 : 8'h04;
      4:  b = alt ? 8'h05 : 8'h24;
      5:  b = alt ? 8'h18 : 8'hB8;
      6:  b = alt ? 8'h18 : 8'h1B;
      7:  b = alt ? 8'h01 : 8'h00;
      8:  b = 8'h0D;
      9:  b = 8'hF0;
      10: b = 8'h05;
      11: b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter logic [WORD_W-1:0] LOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEn,
  input  wdogStrb_t         strb,
  output logic [WORD_W-1:0] loadVal,
  output logic [WORD_W-1:0] count,
  output logic              rawInt,
  output logic              rstSt
);
  logic running;
  logic atEnd;

  assign atEnd = (count <= WORD_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadVal <= LOAD_INIT;
      count   <= LOAD_INIT;
      running <= 1'b1;
      rawInt  <= 1'b0;
      rstSt   <= 1'b0;
    end else if (strb.loadWr) begin
      loadVal <= strb.data;
      count   <= strb.data;
      running <= 1'b1;
    end else if (strb.intClr) begin
      rawInt <= 1'b0;
      count  <= loadVal;
    end else if (cntEn && running) begin
      if (atEnd) begin
        if (!rawInt) begin
          rawInt <= 1'b1;
          count  <= loadVal;
        end else begin
          rstSt   <= 1'b1;
          running <= 1'b0;
          count   <= '0;
        end
      end else begin
        count <= count - WORD_W'(1);
      end
    end
  end

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWr |=> (running && count == $past(strb.data))); // R3
  AST_FIRST_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && running && count == WORD_W'(1) && !rawInt && !strb.loadWr && !strb.intClr)
      |=> (rawInt && !$rose(rstSt) && count == $past(loadVal))); // R4
  AST_RST_AFTER_INT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstSt) |-> $past(rawInt)); // R5
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strb.loadWr && !strb.intClr) |=> (count == $past(count))); // R5
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter bit                VARIANT    = 1'b0,
  parameter logic [WORD_W-1:0] UNLOCK_KEY = 32'h1ACC_E551
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [WORD_W-1:0] pWdata,
  output logic [WORD_W-1:0] pRdata,
  input  logic [WORD_W-1:0] loadVal,
  input  logic [WORD_W-1:0] count,
  input  logic              rawInt,
  input  logic              rstSt,
  output wdogStrb_t         strb,
  output logic              wdogInt,
  output logic              wdogRstReq
);
  localparam bit HAS_TEST = !VARIANT;

  logic [1:0] ctrlQ;
  logic       lockQ;
  logic       itcrQ;
  logic [1:0] itopQ;
  logic       wrAcc;
  logic       wrOk;
  logic       ctrlFrozen;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  assign wrAcc      = pSel && pEnable && pWrite;
  assign wrOk       = wrAcc && (!lockQ || hit(pAddr, OFF_LOCK));
  assign ctrlFrozen = VARIANT && ctrlQ[0];

  assign strb.loadWr = wrOk && hit(pAddr, OFF_LOAD);
  assign strb.intClr = HAS_TEST && wrOk && hit(pAddr, OFF_CLR);
  assign strb.data   = pWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      lockQ <= 1'b0;
      itcrQ <= 1'b0;
      itopQ <= '0;
    end else if (wrOk) begin
      if (hit(pAddr, OFF_LOCK)) lockQ <= (pWdata != UNLOCK_KEY);
      if (hit(pAddr, OFF_CTRL) && !ctrlFrozen) ctrlQ <= pWdata[1:0];
      if (HAS_TEST && hit(pAddr, OFF_ITC)) itcrQ <= pWdata[0];
      if (HAS_TEST && hit(pAddr, OFF_ITO)) itopQ <= pWdata[1:0];
    end
  end

  always_comb begin
    pRdata = '0;
    if (hit(pAddr, OFF_LOAD)) pRdata = loadVal;
    if (hit(pAddr, OFF_CNT))  pRdata = count;
    if (hit(pAddr, OFF_CTRL)) pRdata = WORD_W'(ctrlQ);
    if (hit(pAddr, OFF_RAW))  pRdata = WORD_W'(rawInt);
    if (hit(pAddr, OFF_MSK))  pRdata = WORD_W'(rawInt && ctrlQ[0]);
    if (hit(pAddr, OFF_LOCK)) pRdata = WORD_W'(lockQ);
    if (HAS_TEST && hit(pAddr, OFF_ITC)) pRdata = WORD_W'(itcrQ);
    for (int i = 0; i < ID_NUM; i++) begin
      if (hit(pAddr, ID_BASE + 4 * i)) pRdata = WORD_W'(idByte(i, VARIANT));
    end
  end

  always_comb begin
    if (itcrQ) begin
      wdogInt    = itopQ[1];
      wdogRstReq = itopQ[0];
    end else begin
      wdogInt    = rawInt && ctrlQ[0];
      wdogRstReq = rstSt && ctrlQ[1];
    end
  end

  AST_LOCK_BLOCKS_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && wrAcc && hit(pAddr, OFF_CTRL)) |=> $stable(ctrlQ)); // R8
  AST_VARIANT_CTRL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (VARIANT && ctrlQ[0]) |=> ctrlQ[0]); // R11
  AST_NO_TEST_IN_VARIANT: assert property (@(posedge clk) disable iff (!rstN)
    VARIANT |-> !itcrQ); // R11
endmodule

// File: rtl/wdog_apb_twostage.sv
module wdog_apb_twostage
  import wdog_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter bit                VARIANT    = 1'b0,
  parameter logic [WORD_W-1:0] UNLOCK_KEY = 32'h1ACC_E551,
  parameter logic [WORD_W-1:0] LOAD_INIT  = '1
) (
  input  logic              pClk,
  input  logic              pResetN,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [WORD_W-1:0] pWdata,
  output logic [WORD_W-1:0] pRdata,
  output logic              pReady,
  output logic              pSlvErr,
  input  logic              cntEn,
  output logic              wdogInt,
  output logic              wdogRstReq
);
  wdogStrb_t         strb;
  logic [WORD_W-1:0] loadVal;
  logic [WORD_W-1:0] count;
  logic              rawInt;
  logic              rstSt;

  assign pReady  = 1'b1;
  assign pSlvErr = 1'b0;

  wdog_regs #(
    .ADDR_W(ADDR_W), .VARIANT(VARIANT), .UNLOCK_KEY(UNLOCK_KEY)
  ) regs_i (
    .clk(pClk), .rstN(pResetN), .pSel(pSel), .pEnable(pEnable),
    .pWrite(pWrite), .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata),
    .loadVal(loadVal), .count(count), .rawInt(rawInt), .rstSt(rstSt),
    .strb(strb), .wdogInt(wdogInt), .wdogRstReq(wdogRstReq)
  );

  wdog_core #(.LOAD_INIT(LOAD_INIT)) core_i (
    .clk(pClk), .rstN(pResetN), .cntEn(cntEn), .strb(strb),
    .loadVal(loadVal), .count(count), .rawInt(rawInt), .rstSt(rstSt)
  );

  AST_BUS_OK: assert property (@(posedge pClk) disable iff (!pResetN)
    (pReady && !pSlvErr)); // R12
endmodule

// File: tb/wdog_apb_twostage_tb_top.sv
module wdog_apb_twostage_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pSel [2];
  logic pEnable [2];
  logic pWrite [2];
  logic [11:0] pAddr [2];
  logic [31:0] pWdata [2];
  logic [31:0] pRdata [2];
  logic pReady [2];
  logic pSlvErr [2];
  logic cntEn [2];
  logic wInt [2];
  logic wRst [2];
  int nChk = 0;
  int nErr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdog_apb_twostage #(.VARIANT(1'b0)) dut_i (
    .pClk(clk), .pResetN(rstN), .pSel(pSel[0]), .pEnable(pEnable[0]),
    .pWrite(pWrite[0]), .pAddr(pAddr[0]), .pWdata(pWdata[0]), .pRdata(pRdata[0]),
    .pReady(pReady[0]), .pSlvErr(pSlvErr[0]), .cntEn(cntEn[0]),
    .wdogInt(wInt[0]), .wdogRstReq(wRst[0]));

  wdog_apb_twostage #(.VARIANT(1'b1)) dutV_i (
    .pClk(clk), .pResetN(rstN), .pSel(pSel[1]), .pEnable(pEnable[1]),
    .pWrite(pWrite[1]), .pAddr(pAddr[1]), .pWdata(pWdata[1]), .pRdata(pRdata[1]),
    .pReady(pReady[1]), .pSlvErr(pSlvErr[1]), .cntEn(cntEn[1]),
    .wdogInt(wInt[1]), .wdogRstReq(wRst[1]));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apbWr(input int u, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    pSel[u] = 1; pEnable[u] = 0; pWrite[u] = 1; pAddr[u] = a; pWdata[u] = d;
    @(negedge clk);
    pEnable[u] = 1;
    @(negedge clk);
    pSel[u] = 0; pEnable[u] = 0; pWrite[u] = 0;
  endtask

  task automatic apbRd(input int u, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    pSel[u] = 1; pEnable[u] = 0; pWrite[u] = 0; pAddr[u] = a;
    @(negedge clk);
    pEnable[u] = 1;
    #1 d = pRdata[u];
    @(negedge clk);
    pSel[u] = 0; pEnable[u] = 0;
  endtask

  task automatic rdChk(input int u, input logic [11:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    apbRd(u, a, d);
    chk(req, d, exp);
  endtask

  task automatic tick(input int u, input int n);
    if (n > 0) begin
      @(negedge clk);
      cntEn[u] = 1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      cntEn[u] = 0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  function automatic logic [7:0] expId(input int i, input bit alt);
    logic [7:0] t0 [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h24, 8'hB8, 8'h1B, 8'h00,
                            8'h0D, 8'hF0, 8'h05, 8'hB1};
    logic [7:0] t1 [8] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h05, 8'h18, 8'h18, 8'h01};
    return (alt && i < 8) ? t1[i] : t0[i];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", nErr, nChk + 1);
      $finish;
    end
  end

  initial begin
    for (int u = 0; u < 2; u++) begin
      pSel[u] = 0; pEnable[u] = 0; pWrite[u] = 0; pAddr[u] = '0; pWdata[u] = '0; cntEn[u] = 0;
    end
    doReset();

    // R1 reset state
    rdChk(0, 12'h000, 32'hFFFF_FFFF, "R1 load");
    rdChk(0, 12'h004, 32'hFFFF_FFFF, "R1 count");
    rdChk(0, 12'h008, 0, "R1 ctrl");
    rdChk(0, 12'h010, 0, "R1 raw");
    rdChk(0, 12'hC00, 0, "R1 lock");
    rdChk(0, 12'hF00, 0, "R1 itcr");
    chk("R1 int", wInt[0], 0);
    chk("R1 rst", wRst[0], 0);
    tick(0, 3);
    rdChk(0, 12'h004, 32'hFFFF_FFFC, "R1 running after reset");

    // R12 unmapped / unaligned and bus signals
    rdChk(0, 12'h020, 0, "R12 unmapped");
    rdChk(0, 12'h002, 0, "R12 unaligned");
    chk("R12 ready", pReady[0], 1);
    chk("R12 slverr", pSlvErr[0], 0);

    // R10 / R11 identification bytes
    for (int i = 0; i < 12; i++) begin
      rdChk(0, 12'(12'hFD0 + 4 * i), 32'(expId(i, 0)), "R10 id");
      rdChk(1, 12'(12'hFD0 + 4 * i), 32'(expId(i, 1)), "R11 id");
    end

    // R2 / R3 sweep of load value and tick count
    for (int l = 1; l <= 6; l++) begin
      for (int n = 0; n < l; n++) begin
        apbWr(0, 12'h000, 32'(l));
        tick(0, n);
        rdChk(0, 12'h004, 32'(l - n), "R2 count sweep");
      end
    end
    rdChk(0, 12'h000, 6, "R3 reload stored");
    apbWr(0, 12'h004, 32'h55);
    apbWr(0, 12'h010, 32'h1);
    rdChk(0, 12'h004, 1, "R2 write to count ignored");
    rdChk(0, 12'h010, 0, "R2 write to raw ignored");

    // R4 first expiry
    apbWr(0, 12'h000, 4);
    tick(0, 4);
    rdChk(0, 12'h010, 1, "R4 raw set");
    rdChk(0, 12'h004, 4, "R4 reloaded");
    chk("R7 int masked off", wInt[0], 0);
    rdChk(0, 12'h014, 0, "R7 masked read off");
    apbWr(0, 12'h008, 3);
    chk("R7 int on", wInt[0], 1);
    rdChk(0, 12'h014, 1, "R7 masked read on");

    // R5 second expiry
    tick(0, 3);
    chk("R5 no reset yet", wRst[0], 0);
    tick(0, 1);
    chk("R5 reset out", wRst[0], 1);
    rdChk(0, 12'h004, 0, "R5 frozen");
    tick(0, 3);
    rdChk(0, 12'h004, 0, "R5 stays frozen");

    // R3 restart after freeze
    apbWr(0, 12'h000, 3);
    rdChk(0, 12'h004, 3, "R3 restart load");
    tick(0, 1);
    rdChk(0, 12'h004, 2, "R3 counting again");

    // R6 interrupt clear
    doReset();
    apbWr(0, 12'h008, 3);
    apbWr(0, 12'h000, 3);
    tick(0, 3);
    chk("R6 int before clear", wInt[0], 1);
    tick(0, 1);
    apbWr(0, 12'h00C, 32'hDEAD_BEEF);
    chk("R6 int cleared", wInt[0], 0);
    rdChk(0, 12'h010, 0, "R6 raw cleared");
    rdChk(0, 12'h004, 3, "R6 reloaded");
    tick(0, 3);
    rdChk(0, 12'h010, 1, "R6 raw again");
    chk("R6 no reset", wRst[0], 0);

    // R7 control sweep with raw and reset status both set
    doReset();
    apbWr(0, 12'h000, 2);
    tick(0, 4);
    for (int c = 0; c < 4; c++) begin
      apbWr(0, 12'h008, 32'hFFFF_FFFC | 32'(c));
      rdChk(0, 12'h008, 32'(c), "R7 ctrl bits");
      chk("R7 int gate", wInt[0], c[0]);
      chk("R7 rst gate", wRst[0], c[1]);
    end

    // R9 integration override
    apbWr(0, 12'h008, 0);
    apbWr(0, 12'hF00, 1);
    rdChk(0, 12'hF00, 1, "R9 itcr");
    for (int v = 0; v < 4; v++) begin
      apbWr(0, 12'hF04, 32'(v));
      chk("R9 rst from bit0", wRst[0], v[0]);
      chk("R9 int from bit1", wInt[0], v[1]);
      rdChk(0, 12'hF04, 0, "R9 output reg reads 0");
    end
    apbWr(0, 12'hF00, 0);
    chk("R9 override off", wRst[0], 0);

    // R8 lock
    doReset();
    apbWr(0, 12'h008, 1);
    apbWr(0, 12'hC00, 0);
    rdChk(0, 12'hC00, 1, "R8 locked");
    apbWr(0, 12'h008, 2);
    rdChk(0, 12'h008, 1, "R8 ctrl blocked");
    apbWr(0, 12'h000, 7);
    rdChk(0, 12'h000, 32'hFFFF_FFFF, "R8 load blocked");
    apbWr(0, 12'hC00, 32'h1ACC_E551);
    rdChk(0, 12'hC00, 0, "R8 unlocked");
    apbWr(0, 12'h000, 7);
    rdChk(0, 12'h000, 7, "R8 load after unlock");

    // R11 variant rules
    apbWr(1, 12'h008, 1);
    rdChk(1, 12'h008, 1, "R11 ctrl set");
    apbWr(1, 12'h008, 2);
    rdChk(1, 12'h008, 1, "R11 ctrl frozen");
    apbWr(1, 12'hF00, 1);
    apbWr(1, 12'hF04, 3);
    rdChk(1, 12'hF00, 0, "R11 itcr absent");
    chk("R11 no override int", wInt[1], 0);
    apbWr(1, 12'h000, 2);
    tick(1, 2);
    apbWr(1, 12'h00C, 1);
    rdChk(1, 12'h010, 1, "R11 clear ignored");
    rdChk(1, 12'h004, 2, "R11 count untouched");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule